// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block moves data between two buses, side A and side B. It has one independent path for each direction. Each path has a storage element that works in one of three modes, chosen by that path's capture-enable level and the activity on its strobe input. The element can pass its source straight through. It can keep its content unchanged. It can also load its source when the strobe falls. The outputs of each path are gated by that path's output enable. The A-to-B enable is active high and the B-to-A enable is active low. Each side has its own data output and valid flag, so the block models a high-impedance output without any internal tristate logic. A wrapper outside the block can resolve these into a shared wire if needed.

The strobe and capture-enable inputs are ordinary signals, sampled by the block's system clock `clk`. A strobe fall is seen when the strobe was high at one `clk` edge and is low at the next. At that edge the source value is loaded into storage. While the capture enable is high, the output follows the source with no clock delay. Storage also tracks the source at every `clk` edge during that time, so when the enable drops, the last sampled value is kept. An asynchronous active-low reset clears both storage elements to zero.

Top module: `ubr_bus_register`

## Requirements
- R1: While a path's capture enable is high and its output is enabled, its data output equals its source input in the same cycle (pass-through).
- R2: While the capture enable is low and no strobe fall is seen, the stored value and the enabled output stay unchanged, whatever the source does.
- R3: With the capture enable low, a strobe sampled high at one `clk` edge and low at the next loads the source into storage at that second edge. The enabled output shows the loaded value from then on.
- R4: With the capture enable low, a strobe rise (sampled low, then high) leaves storage unchanged.
- R5: The capture enable has priority over the strobe. When it drops, storage keeps the source value sampled at the last `clk` edge at which the enable was high.
- R6: The B-side output enable `b_oe` is active high. When it is 1, `b_vld` is 1 and `b_q` carries the path value. When it is 0, `b_vld` is 0 and `b_q` is all zeros.
- R7: The A-side output enable `a_oe_n` is active low. When it is 0, `a_vld` is 1 and `a_q` carries the path value. When it is 1, `a_vld` is 0 and `a_q` is all zeros.
- R8: While `rst_n` is low, both storage elements are cleared to zero. After reset, with pass-through off, both enabled outputs read zero.
- R9: The two directions work independently and may be enabled at the same time. Activity on one path never changes the other.
- R10: The data width is a parameter, 36 bits by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and capture enables |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_d | input | W | A-side source for the A-to-B path |
| ab_cap | input | 1 | A-to-B capture enable (high: pass-through) |
| ab_stb | input | 1 | A-to-B strobe (a fall loads storage) |
| b_oe | input | 1 | B-side output enable, active high |
| b_q | output | W | B-side data output, zero when disabled |
| b_vld | output | 1 | B-side output driven flag |
| b_d | input | W | B-side source for the B-to-A path |
| ba_cap | input | 1 | B-to-A capture enable (high: pass-through) |
| ba_stb | input | 1 | B-to-A strobe (a fall loads storage) |
| a_oe_n | input | 1 | A-side output enable, active low |
| a_q | output | W | A-side data output, zero when disabled |
| a_vld | output | 1 | A-side output driven flag |

## Verification
The bench targets the release of the capture enable. A design that loads the source of the release cycle, rather than the last value sampled while the enable was high, shows a new value where the old one should stay. It makes strobe rises while holding. A design that triggers on either edge, or on the rising edge, would load new data there. It toggles the two output enables with their opposite polarities and drives both paths together. A swapped polarity shows up as a valid flag that is inverted, and cross-wired paths show up as one side copying the other.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CAPTURE = 2'd2
    } ubr_mode_e;
endpackage

// File: rtl/ubr_mode_decode.sv
module ubr_mode_decode
    import ubr_pkg::*;
(
    input  logic      cap_en,
    input  logic      stb,
    input  logic      stb_hist,
    output ubr_mode_e mode
);
    always_comb begin
        if (cap_en) begin
            mode = MODE_PASS;
        end else if (stb_hist && !stb) begin
            mode = MODE_CAPTURE;
        end else begin
            mode = MODE_HOLD;
        end
    end
endmodule

// File: rtl/ubr_out_gate.sv
module ubr_out_gate #(
    parameter int W       = 36,
    parameter bit OE_LOW  = 1'b0
) (
    input  logic [W-1:0] view,
    input  logic         oe_raw,
    output logic [W-1:0] q,
    output logic         vld
);
    logic en;

    generate
        if (OE_LOW) begin : g_low
            assign en = ~oe_raw;
        end else begin : g_high
            assign en = oe_raw;
        end
    endgenerate

    assign vld = en;
    assign q   = en ? view : '0;
endmodule

// File: rtl/ubr_path.sv
module ubr_path
    import ubr_pkg::*;
#(
    parameter int W      = 36,
    parameter bit OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         cap_en,
    input  logic         stb,
    input  logic         oe_raw,
    output logic [W-1:0] q,
    output logic         vld
);
    typedef struct packed {
        logic [W-1:0] store;
        logic         stb_hist;
    } path_st_t;

    path_st_t  st_d, st_q;
    ubr_mode_e mode;
    logic [W-1:0] view;

    ubr_mode_decode i_dec (
        .cap_en   (cap_en),
        .stb      (stb),
        .stb_hist (st_q.stb_hist),
        .mode     (mode)
    );

    always_comb begin
        st_d          = st_q;
        st_d.stb_hist = stb;
        case (mode)
            MODE_PASS:    st_d.store = src;
            MODE_CAPTURE: st_d.store = src;
            default:      st_d.store = st_q.store;
        endcase
        view = cap_en ? src : st_q.store;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ubr_out_gate #(.W(W), .OE_LOW(OE_LOW)) i_gate (
        .view   (view),
        .oe_raw (oe_raw),
        .q      (q),
        .vld    (vld)
    );

    assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && vld) |-> (q == src));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !(st_q.stb_hist && !stb)) |=> $stable(st_q.store));
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && st_q.stb_hist && !stb) |=> (st_q.store == $past(src)));
    assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !st_q.stb_hist && stb) |=> $stable(st_q.store));
    assert_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (st_q.store == $past(src)));
    assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (q == '0));
endmodule

// File: rtl/ubr_bus_register.sv
module ubr_bus_register #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_d,
    input  logic         ab_cap,
    input  logic         ab_stb,
    input  logic         b_oe,
    output logic [W-1:0] b_q,
    output logic         b_vld,
    input  logic [W-1:0] b_d,
    input  logic         ba_cap,
    input  logic         ba_stb,
    input  logic         a_oe_n,
    output logic [W-1:0] a_q,
    output logic         a_vld
);
    ubr_path #(.W(W), .OE_LOW(1'b0)) i_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (a_d),
        .cap_en (ab_cap),
        .stb    (ab_stb),
        .oe_raw (b_oe),
        .q      (b_q),
        .vld    (b_vld)
    );

    ubr_path #(.W(W), .OE_LOW(1'b1)) i_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (b_d),
        .cap_en (ba_cap),
        .stb    (ba_stb),
        .oe_raw (a_oe_n),
        .q      (a_q),
        .vld    (a_vld)
    );

    assert_b_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld == b_oe);
    assert_a_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld == !a_oe_n);
endmodule

// File: tb/test_ubr_bus_register.sv
module test_ubr_bus_register;
    localparam int W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a_d, b_d, a_q, b_q;
    logic ab_cap, ab_stb, b_oe, ba_cap, ba_stb, a_oe_n, a_vld, b_vld;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ubr_bus_register #(.W(W)) i_ubr_bus_register (
        .clk(clk), .rst_n(rst_n),
        .a_d(a_d), .ab_cap(ab_cap), .ab_stb(ab_stb), .b_oe(b_oe),
        .b_q(b_q), .b_vld(b_vld),
        .b_d(b_d), .ba_cap(ba_cap), .ba_stb(ba_stb), .a_oe_n(a_oe_n),
        .a_q(a_q), .a_vld(a_vld)
    );

    // reference model: what each path holds, per requirement
    logic [W-1:0] m_ab, m_ba;
    bit m_stb_ab, m_stb_ba;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_stb_ab = 0; m_stb_ba = 0;
        end else begin
            if (ab_cap || (m_stb_ab && !ab_stb)) m_ab = a_d;
            if (ba_cap || (m_stb_ba && !ba_stb)) m_ba = b_d;
            m_stb_ab = ab_stb;
            m_stb_ba = ba_stb;
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [W-1:0] eb, ea;
        eb = b_oe ? (ab_cap ? a_d : m_ab) : '0;
        ea = !a_oe_n ? (ba_cap ? b_d : m_ba) : '0;
        check(!b_oe ? "R6" : (ab_cap ? "R1" : "R2/R3/R4"), b_q, eb);
        check("R6", {{(W-1){1'b0}}, b_vld}, {{(W-1){1'b0}}, b_oe});
        check(a_oe_n ? "R7" : (ba_cap ? "R1/R9" : "R2/R3/R9"), a_q, ea);
        check("R7", {{(W-1){1'b0}}, a_vld}, {{(W-1){1'b0}}, !a_oe_n});
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [W-1:0] rnd();
        return W'({$urandom, $urandom});
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    logic [W-1:0] v1, v2, v3;

    initial begin
        a_d = 36'h1_2345_6789; b_d = 36'h9_8765_4321;
        ab_cap = 1; ab_stb = 0; b_oe = 1; ba_cap = 1; ba_stb = 0; a_oe_n = 0;
        repeat (3) @(negedge clk);
        // R8: during reset storage clears; pass-through still shows source
        ab_cap = 0; ba_cap = 0;
        #2;
        check("R8", b_q, '0);
        check("R8", a_q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R8", b_q, '0);
        check("R10", W'($bits(b_q)), W'(36));

        // R1: pass-through, same cycle
        v1 = 36'hA_BCDE_F012;
        ab_cap = 1; a_d = v1;
        #2 check("R1", b_q, v1);
        tick();

        // R5: drop enable while changing source, old value is kept
        v2 = 36'h5_5555_AAAA;
        ab_cap = 0; a_d = v2;
        #2 check("R5", b_q, v1);
        tick();

        // R2: source changes, strobe steady low
        a_d = rnd(); tick(); a_d = rnd(); tick();
        #2 check("R2", b_q, v1);

        // R4: strobe rises with cap low
        a_d = 36'h0_0F0F_0F0F; ab_stb = 1; tick();
        #2 check("R4", b_q, v1);

        // R3: strobe falls, loads current source
        v3 = 36'hC_3C3C_3C3C;
        a_d = v3; ab_stb = 0; tick();
        #2 check("R3", b_q, v3);
        a_d = rnd(); tick();
        #2 check("R3", b_q, v3);

        // R6: disable B side
        b_oe = 0;
        #2 check("R6", b_q, '0);
        check("R6", {{(W-1){1'b0}}, b_vld}, '0);
        b_oe = 1;

        // R7: A side active low
        a_oe_n = 1;
        #2 check("R7", a_q, '0);
        check("R7", {{(W-1){1'b0}}, a_vld}, '0);
        a_oe_n = 0;
        #2 check("R7", {{(W-1){1'b0}}, a_vld}, W'(1));

        // R9: both paths active together, independent values
        ab_cap = 1; ba_cap = 1; a_d = 36'h1_1111_1111; b_d = 36'h2_2222_2222;
        #2 check("R9", b_q, 36'h1_1111_1111);
        check("R9", a_q, 36'h2_2222_2222);
        tick();
        ab_cap = 0; ba_cap = 0; ba_stb = 1; tick();
        b_d = 36'h3_3333_3333; ba_stb = 0; tick();
        #2 check("R9", a_q, 36'h3_3333_3333);
        check("R9", b_q, 36'h1_1111_1111);

        // mixed traffic against the model on every clock
        for (int i = 0; i < 3000; i++) begin
            a_d = rnd(); b_d = rnd();
            if ($urandom_range(0, 7) == 0) ab_cap = ~ab_cap;
            if ($urandom_range(0, 7) == 0) ba_cap = ~ba_cap;
            if ($urandom_range(0, 2) == 0) ab_stb = ~ab_stb;
            if ($urandom_range(0, 2) == 0) ba_stb = ~ba_stb;
            if ($urandom_range(0, 15) == 0) b_oe = ~b_oe;
            if ($urandom_range(0, 15) == 0) a_oe_n = ~a_oe_n;
            tick();
        end
        finish_up();
    end
endmodule